// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask Compare

This block gathers interrupt requests from a set of sources (37 by default), keeps one pending flag per source, and presents to the processor the single most urgent request. Each maskable source owns a programmable 3-bit urgency level. Level 0 parks the source, and levels 1 to 6 rank it. A group of non-maskable sources occupies the lowest source indices and is fixed at level 7. Every source maps to its own vector, computed as a base value plus the source index.

The processor side holds a 3-bit mask threshold. An enable command with a value loads that value into the mask. A disable command is the same as loading 7. When the winning request's level is at or above the mask, the block raises `irq_o` and shows the vector and level. Pulsing `ack_i` while `irq_o` is high retires that request. Request lines are edge-latched, so a line held high is taken only once per rising edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, `irq_vec_o` and `irq_lvl_o` are 0, `mask_o` is 7, and every maskable level register holds 0.
- R2: A 0-to-1 transition on `req_i[k]` sets the pending flag of source k at the next clock edge. A line that stays high after its request is acknowledged is not taken again until it goes low and rises again.
- R3: Sources with index below `N_NMI` (9 by default) always have level 7. A pending one is presented even when the mask is 7.
- R4: When `lvl_we_i` is high, `lvl_data_i` is written into the level register of maskable source `lvl_addr_i`. A write whose value is 7, or whose address names a non-maskable or nonexistent source, is ignored.
- R5: A source at level 0 is never presented. Its pending flag is kept, and it is presented once a nonzero level is written.
- R6: When `mask_we_i` is high, `mask_val_i` is loaded into the mask. `mask_o` and the acceptance decision use the new value from the next cycle on.
- R7: Among pending sources with a nonzero level, the one with the highest level is presented. When levels tie, the lowest source index wins.
- R8: `irq_o` is high exactly when a presented request exists and its level is at or above the mask. `irq_vec_o` then equals `VEC_BASE` (0x10 by default) plus the source index, and `irq_lvl_o` equals its level. Both are 0 while `irq_o` is low.
- R9: `ack_i` sampled high while `irq_o` is high clears only the presented source's pending flag. `ack_i` while `irq_o` is low has no effect.
- R10: A rising edge on another source in the same cycle as an acknowledge is latched and not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Request lines, edge-latched |
| lvl_we_i | input | 1 | Level register write strobe |
| lvl_addr_i | input | IDX_W | Source index being written |
| lvl_data_i | input | 3 | New level value |
| mask_we_i | input | 1 | Mask load strobe (enable-with-value or disable) |
| mask_val_i | input | 3 | Mask value to load (7 for disable) |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | Request accepted against the mask |
| irq_vec_o | output | VEC_W | Vector of the accepted request |
| irq_lvl_o | output | 3 | Level of the accepted request |
| mask_o | output | 3 | Current mask threshold |

## Verification
Two events can land on the same edge: the acknowledge that clears the presented source, and a new rising edge on a different source. The bench drives an acknowledge together with a fresh request on a level-4 source. It then expects that source to be presented in the next cycle, ahead of the remaining level-3 request. A second case drives a level-7 pair that rises on the same edge while the mask is 7, and the lower index must win. Both outcomes are judged through the scoreboard queue against the vector, level and mask predicted from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef logic [2:0] lvl_t;
   localparam lvl_t LVL_OFF  = 3'd0;
   localparam lvl_t LVL_NMI  = 3'd7;
   localparam lvl_t MASK_RST = 3'd7;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 37
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] req_q, pend_q, rise;

   assign rise   = req_i & ~req_q;
   assign pend_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         req_q  <= req_i;
         pend_q <= (pend_q & ~clr_i) | rise;
      end
   end

   // R9: at most one source cleared per acknowledge
   p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_i));
   // R9: a cleared source without a new edge is no longer pending
   p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
   // R2: a rising edge always leaves the source pending
   p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs
   import irq_pkg::*;
#(
   parameter int N     = 37,
   parameter int N_NMI = 9,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] addr_i,
   input  lvl_t             data_i,
   output lvl_t [N-1:0]     lvl_o
);
   logic wr_ok;
   assign wr_ok = we_i && (data_i != LVL_NMI);

   for (genvar i = 0; i < N; i++) begin : g_src
      if (i < N_NMI) begin : g_fixed
         assign lvl_o[i] = LVL_NMI;
      end else begin : g_prog
         lvl_t lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvl_q <= LVL_OFF;
            else if (wr_ok && (addr_i == IDX_W'(i)))
               lvl_q <= data_i;
         end
         assign lvl_o[i] = lvl_q;
         // R4: a maskable source never reaches the fixed top level
         p_no_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_q != LVL_NMI);
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int N     = 37,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend_i,
   input  lvl_t [N-1:0]     lvl_i,
   output logic             win_valid_o,
   output logic [IDX_W-1:0] win_idx_o,
   output lvl_t             win_lvl_o
);
   always_comb begin
      win_valid_o = 1'b0;
      win_idx_o   = '0;
      win_lvl_o   = LVL_OFF;
      // scan from the top so that ties settle on the lowest index
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i] && (lvl_i[i] != LVL_OFF) &&
             (!win_valid_o || (lvl_i[i] >= win_lvl_o))) begin
            win_valid_o = 1'b1;
            win_idx_o   = IDX_W'(unsigned'(i));
            win_lvl_o   = lvl_i[i];
         end
      end
   end

   // R7: the winner is a pending source
   p_win_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> pend_i[win_idx_o]);
   // R5: a parked source never wins
   p_win_not_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> (lvl_i[win_idx_o] != LVL_OFF));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int N_SRC    = 37,
   parameter int N_NMI    = 9,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 16,
   parameter int IDX_W    = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   input  logic             lvl_we_i,
   input  logic [IDX_W-1:0] lvl_addr_i,
   input  logic [2:0]       lvl_data_i,
   input  logic             mask_we_i,
   input  logic [2:0]       mask_val_i,
   input  logic             ack_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] irq_vec_o,
   output logic [2:0]       irq_lvl_o,
   output logic [2:0]       mask_o
);
   localparam int VEC_TOP = VEC_BASE + N_SRC - 1;

   if (N_SRC < 2) begin : g_chk_src
      $error("irq_prio_ctrl: N_SRC must be at least 2");
   end
   if (N_NMI > N_SRC || N_NMI < 0) begin : g_chk_nmi
      $error("irq_prio_ctrl: N_NMI out of range");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_chk_vec
      $error("irq_prio_ctrl: vectors do not fit VEC_W");
   end

   logic [N_SRC-1:0] pend, clr, nmi_sel;
   lvl_t [N_SRC-1:0] lvl;
   logic             win_valid;
   logic [IDX_W-1:0] win_idx;
   lvl_t             win_lvl;
   lvl_t             mask_q;

   irq_pend_bank #(.N(N_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .pend_o(pend)
   );

   irq_level_regs #(.N(N_SRC), .N_NMI(N_NMI), .IDX_W(IDX_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .we_i(lvl_we_i), .addr_i(lvl_addr_i),
      .data_i(lvl_data_i), .lvl_o(lvl)
   );

   irq_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .lvl_i(lvl),
      .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= MASK_RST;
      else if (mask_we_i) mask_q <= mask_val_i;
   end

   assign irq_o     = win_valid && (win_lvl >= mask_q);
   assign irq_vec_o = irq_o ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : '0;
   assign irq_lvl_o = irq_o ? win_lvl : LVL_OFF;
   assign mask_o    = mask_q;

   always_comb begin
      clr = '0;
      if (ack_i && irq_o) clr[win_idx] = 1'b1;
   end

   always_comb begin
      nmi_sel = '0;
      for (int i = 0; i < N_NMI; i++) nmi_sel[i] = 1'b1;
   end

   // R6: a mask load is visible on the next cycle
   p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_o == $past(mask_val_i)));
   // R3: a pending non-maskable source is always accepted at level 7
   p_nmi_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & nmi_sel)) |-> (irq_o && irq_lvl_o == LVL_NMI));
   // R8: an accepted request never sits below the mask
   p_above_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_lvl_o >= mask_o && irq_lvl_o != LVL_OFF));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
   localparam int N = 37;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_i = '0;
   logic          lvl_we_i = 1'b0;
   logic [IW-1:0] lvl_addr_i = '0;
   logic [2:0]    lvl_data_i = '0;
   logic          mask_we_i = 1'b0;
   logic [2:0]    mask_val_i = '0;
   logic          ack_i = 1'b0;
   logic          irq_o;
   logic [7:0]    irq_vec_o;
   logic [2:0]    irq_lvl_o, mask_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit    v;
      int    vec;
      int    lvl;
      int    mask;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .lvl_we_i(lvl_we_i),
      .lvl_addr_i(lvl_addr_i), .lvl_data_i(lvl_data_i), .mask_we_i(mask_we_i),
      .mask_val_i(mask_val_i), .ack_i(ack_i), .irq_o(irq_o),
      .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o), .mask_o(mask_o)
   );

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         wait (sb.size() != 0);
         begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_o !== e.v || int'(irq_vec_o) != e.vec ||
                int'(irq_lvl_o) != e.lvl || int'(mask_o) != e.mask) begin
               failures++;
               $display("FAIL %s actual irq=%0b vec=%0h lvl=%0d mask=%0d expected irq=%0b vec=%0h lvl=%0d mask=%0d",
                        e.tag, irq_o, irq_vec_o, irq_lvl_o, mask_o,
                        e.v, e.vec, e.lvl, e.mask);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(bit v, int vec, int lvl, int mask, string tag);
      exp_t e;
      e.v = v; e.vec = vec; e.lvl = lvl; e.mask = mask; e.tag = tag;
      sb.push_back(e);
      #0.2;
   endtask

   task automatic wr_lvl(int idx, int val);
      lvl_we_i = 1'b1; lvl_addr_i = IW'(idx); lvl_data_i = 3'(val);
      tick();
      lvl_we_i = 1'b0;
   endtask

   task automatic set_mask(int val);
      mask_we_i = 1'b1; mask_val_i = 3'(val);
      tick();
      mask_we_i = 1'b0;
   endtask

   task automatic do_ack();
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
   endtask

   initial begin
      #20000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      expect_out(0, 0, 0, 7, "R1 reset state");

      wr_lvl(20, 3); wr_lvl(30, 3); wr_lvl(12, 5); wr_lvl(31, 4);
      set_mask(3);
      expect_out(0, 0, 0, 3, "R6 mask loaded");

      req_i[15] = 1'b1; tick(); req_i[15] = 1'b0; tick();
      expect_out(0, 0, 0, 3, "R5 level-0 source hidden (R1 levels cleared)");

      req_i[30] = 1'b1; tick();
      expect_out(1, 'h2E, 3, 3, "R8 single request");
      req_i[20] = 1'b1; tick();
      expect_out(1, 'h24, 3, 3, "R7 tie lowest index");
      req_i[12] = 1'b1; tick();
      expect_out(1, 'h1C, 5, 3, "R7 highest level");

      set_mask(6);
      expect_out(0, 0, 0, 6, "R6 mask blocks level 5");
      do_ack();
      expect_out(0, 0, 0, 6, "R9 ack while idle ignored");
      set_mask(5);
      expect_out(1, 'h1C, 5, 5, "R9 pending kept after ignored ack");
      do_ack();
      expect_out(0, 0, 0, 5, "R9 ack clears presented source");
      set_mask(3);
      expect_out(1, 'h24, 3, 3, "R9 next source presented");

      req_i[31] = 1'b1;
      do_ack();
      expect_out(1, 'h2F, 4, 3, "R10 edge during ack latched");
      do_ack();
      expect_out(1, 'h2E, 3, 3, "R2 held line not retaken");
      do_ack();
      expect_out(0, 0, 0, 3, "R9 all cleared");

      req_i[12] = 1'b0; tick();
      req_i[12] = 1'b1; tick();
      expect_out(1, 'h1C, 5, 3, "R2 retrigger after low");
      do_ack();
      expect_out(0, 0, 0, 3, "R2 retrigger acked");

      set_mask(7);
      expect_out(0, 0, 0, 7, "R3 disable mask");
      req_i[4] = 1'b1; req_i[2] = 1'b1; tick();
      expect_out(1, 'h12, 7, 7, "R3 nmi passes mask 7, lowest index");
      do_ack();
      expect_out(1, 'h14, 7, 7, "R3 second nmi");
      do_ack();
      expect_out(0, 0, 0, 7, "R3 nmi cleared");

      wr_lvl(3, 1); wr_lvl(22, 7); set_mask(1);
      expect_out(0, 0, 0, 1, "R4 setup");
      req_i[3] = 1'b1; tick();
      expect_out(1, 'h13, 7, 1, "R4 write to nmi ignored");
      do_ack();
      expect_out(0, 0, 0, 1, "R4 nmi acked");
      req_i[22] = 1'b1; tick();
      expect_out(0, 0, 0, 1, "R4 value 7 write ignored");
      wr_lvl(22, 2);
      expect_out(1, 'h26, 2, 1, "R5 pending retained until enabled");
      do_ack();
      expect_out(0, 0, 0, 1, "R9 final clear");

      wait (sb.size() == 0);
      #1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule